// File: doc/BRIEF.md
# Receive IQ Mismatch Coefficient Estimator

This block turns per-chain receive measurements into gain and phase correction coefficients for IQ imbalance. After a start pulse it collects a programmable number of measurement strobes. On each strobe it adds I-branch power, Q-branch power and the signed I·Q cross-correlation of every enabled chain into 32-bit running sums. When the last sample arrives it works through the chains in ascending order. For each chain a single shared restoring divider performs two divisions, and the quotients are saturated into a pair of 7-bit two's-complement coefficients.

A chain is skipped when it is masked off or when one of its two normalising denominators is zero. A skipped chain keeps its previous coefficients and raises its skip flag. A one-cycle completion pulse marks the end of the pass. A correction-enable output is set at that point and stays set until reset, so that the downstream corrector can start applying the coefficients.

Top module: `iqc_est`

## Requirements
- R1: A start pulse clears all sums and the sample count, and it latches the chain mask and the log-count setting. Start takes priority over a measurement strobe in the same cycle, and it abandons any collection or computation in progress.
- R2: Each accepted strobe adds I power, Q power and correlation to the 32-bit wrapping sums of every chain whose mask bit is 1. Sums of chains whose bit is 0 are not touched.
- R3: Collection ends on the accepted strobe that brings the sample count to 2^(N+1), where N is the latched log-count setting. Strobes arriving outside collection are ignored.
- R4: A correlation sum above 0x8000_0000 (read unsigned) is replaced by its two's-complement magnitude, and the chain's sign flag is set. Any other correlation sum, including 0x8000_0000 itself, is used as-is with the sign flag clear.
- R5: The phase denominator is ((Isum>>1)+(Qsum>>1))>>8 and the gain denominator is Qsum>>6. A masked-off chain, or one where either denominator is zero, gets skip=1 and keeps its coefficients. A computed chain gets skip=0.
- R6: The phase coefficient is min(magnitude/phase-denominator, 63). It is negated when the sign flag is clear. It is output as 7-bit two's complement in chain slot c of `coef_phase`, at bits [7c+6:7c].
- R7: The gain coefficient is Isum/gain-denominator − 64, clamped to [−63, +63]. It is output as 7-bit two's complement in bits [7c+6:7c] of `coef_gain`.
- R8: Chain slots run in ascending order. The first slot begins on the clock edge after the last sample. A skipped chain's flag updates at its slot's first edge, and the next slot begins one edge later. A computed chain's outputs update 66 edges after its slot's first edge, and the next slot begins on the following edge.
- R9: `done` is high for exactly one cycle, after the edge on which the last chain's slot finishes. `corr_en` rises on that same edge and stays high until reset.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new estimation pass |
| log_cnt | input | LW (4) | Log-count N; 2^(N+1) samples per pass |
| chain_en | input | NCH (3) | Chain enable mask |
| meas_vld | input | 1 | Measurement strobe |
| meas_ipwr | input | NCH*DW (96) | Per-chain I power, chain c at [32c+31:32c] |
| meas_qpwr | input | NCH*DW (96) | Per-chain Q power |
| meas_corr | input | NCH*DW (96) | Per-chain signed I·Q correlation |
| coef_phase | output | NCH*CW (21) | Per-chain phase coefficient |
| coef_gain | output | NCH*CW (21) | Per-chain gain coefficient |
| skip | output | NCH (3) | Per-chain skipped flag |
| done | output | 1 | One-cycle completion pulse |
| corr_en | output | 1 | Sticky correction enable |

## Verification
A skipped chain's flag is due on the first edge of its slot. A computed chain's coefficients and flag are due 66 edges after that, because the slot spends 33 edges on each division. `done` and `corr_en` follow on the edge that closes the last slot. The bench model builds this schedule in absolute edge numbers at the edge that accepts the last sample. It applies each update on its due edge and compares every output on the falling edge of each cycle, so an update that arrives one edge early or late is reported as a mismatch in that cycle.

// File: rtl/iqc_pkg.sv
// Package: shared types for the IQ coefficient estimator.
// Assumes: nothing beyond standard SystemVerilog.
package iqc_pkg;

    // Sequencer states of the estimator.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_SETUP   = 3'd2,
        ST_DIV_PH  = 3'd3,
        ST_DIV_GN  = 3'd4
    } iqc_state_t;

endpackage

// File: rtl/iqc_accum.sv
// Module: per-chain accumulation of I power, Q power and correlation.
// Assumes: clr and add are never needed together (clr wins); sums wrap
// modulo 2^DW.
module iqc_accum #(
    parameter int NCH = 3,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [NCH-1:0]    mask,
    input  logic [NCH*DW-1:0] in_ip,
    input  logic [NCH*DW-1:0] in_qp,
    input  logic [NCH*DW-1:0] in_cr,
    output logic [NCH*DW-1:0] sum_ip,
    output logic [NCH*DW-1:0] sum_qp,
    output logic [NCH*DW-1:0] sum_cr
);

    for (genvar c = 0; c < NCH; c++) begin : g_chain
        logic [DW-1:0] ip_q, qp_q, cr_q;

        // Clear on request, otherwise add the new sample if this chain is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                ip_q <= '0;
                qp_q <= '0;
                cr_q <= '0;
            end else if (add && mask[c]) begin
                ip_q <= ip_q + in_ip[c*DW +: DW];
                qp_q <= qp_q + in_qp[c*DW +: DW];
                cr_q <= cr_q + in_cr[c*DW +: DW];
            end
        end

        assign sum_ip[c*DW +: DW] = ip_q;
        assign sum_qp[c*DW +: DW] = qp_q;
        assign sum_cr[c*DW +: DW] = cr_q;
    end

endmodule

// File: rtl/iqc_divider.sv
// Module: unsigned restoring divider, one quotient bit per clock.
// Assumes: divisor is non-zero when go is raised. go loads the operands,
// DW steps follow, and fin is high for one cycle with the quotient valid.
module iqc_divider #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic          fin
);

    localparam int CNT_W = $clog2(DW + 1);

    logic [DW-1:0]    rem_q, quo_q, dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW:0]      rem_sh;
    logic [DW:0]      rem_sub;
    logic             fits;

    // One restoring step: shift in the next dividend bit, subtract if possible.
    always_comb begin
        rem_sh  = {rem_q, quo_q[DW-1]};
        rem_sub = rem_sh - {1'b0, dvs_q};
        fits    = (rem_sh >= {1'b0, dvs_q});
    end

    // Iteration registers: load on go, then DW steps, then flag finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            fin   <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CNT_W'(DW);
            fin   <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q <= fits ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
            quo_q <= {quo_q[DW-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            fin   <= (cnt_q == CNT_W'(1));
        end else begin
            fin   <= 1'b0;
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/iqc_coef_calc.sv
// Module: saturates the two quotients into CW-bit two's-complement
// coefficients.
// Assumes: quotients are unsigned. The phase sign comes from the
// correlation sign flag.
module iqc_coef_calc #(
    parameter int DW = 32,
    parameter int CW = 7
) (
    input  logic [DW-1:0] ph_quo,
    input  logic [DW-1:0] gn_quo,
    input  logic          corr_neg,
    output logic [CW-1:0] coef_ph,
    output logic [CW-1:0] coef_gn
);

    localparam int LIM = 2 ** (CW - 1) - 1;
    localparam int OFS = 2 ** (CW - 1);
    localparam logic [DW-1:0] PH_MAX = DW'(LIM);
    localparam logic [DW-1:0] GN_HI  = DW'(OFS + LIM);
    localparam logic [DW-1:0] GN_LO  = DW'(OFS - LIM);

    logic [CW-1:0] ph_mag;

    // Phase: clamp magnitude, then negate when the correlation was not negative.
    always_comb begin
        ph_mag  = (ph_quo > PH_MAX) ? CW'(LIM) : ph_quo[CW-1:0];
        coef_ph = corr_neg ? ph_mag : CW'(~ph_mag + 1'b1);
    end

    // Gain: subtract the offset and clamp symmetrically.
    always_comb begin
        if (gn_quo >= GN_HI)
            coef_gn = CW'(LIM);
        else if (gn_quo <= GN_LO)
            coef_gn = CW'(OFS + 1);
        else
            coef_gn = CW'(gn_quo[CW-1:0] - CW'(OFS));
    end

endmodule

// File: rtl/iqc_est.sv
// Module: top of the IQ mismatch coefficient estimator.
// Collects 2^(N+1) samples, then visits each chain in order. Each chain
// gets a phase division and a gain division on a shared divider, and the
// results are written as saturated coefficients.
// Assumes: start is a single-cycle pulse; measurement inputs are valid
// whenever meas_vld is high.
module iqc_est
    import iqc_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int DW    = 32,
    parameter int CW    = 7,
    parameter int LW    = 4,
    parameter int PH_SH = 8,
    parameter int GN_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     log_cnt,
    input  logic [NCH-1:0]    chain_en,
    input  logic              meas_vld,
    input  logic [NCH*DW-1:0] meas_ipwr,
    input  logic [NCH*DW-1:0] meas_qpwr,
    input  logic [NCH*DW-1:0] meas_corr,
    output logic [NCH*CW-1:0] coef_phase,
    output logic [NCH*CW-1:0] coef_gain,
    output logic [NCH-1:0]    skip,
    output logic              done,
    output logic              corr_en
);

    localparam int SCW   = 2 ** LW + 1;
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

    iqc_state_t        state_q;
    logic [NCH-1:0]    mask_q;
    logic [SCW-1:0]    target_q, cnt_q, cnt_nx;
    logic [IDX_W-1:0]  idx_q;
    logic              neg_q;
    logic [DW-1:0]     phq_q;
    logic [NCH*CW-1:0] coef_ph_q, coef_gn_q;
    logic [NCH-1:0]    skip_q;
    logic              done_q, en_q;

    logic [NCH*DW-1:0] acc_ip, acc_qp, acc_cr;
    logic [DW-1:0]     sel_ip, sel_qp, sel_cr;
    logic [DW-1:0]     corr_mag, den_ph, den_gn;
    logic              corr_neg, chain_live, last_chain;
    logic              div_go, div_fin;
    logic [DW-1:0]     div_a, div_b, div_q;
    logic [CW-1:0]     new_ph, new_gn;

    iqc_accum #(.NCH(NCH), .DW(DW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .add    (state_q == ST_COLLECT && meas_vld),
        .mask   (mask_q),
        .in_ip  (meas_ipwr),
        .in_qp  (meas_qpwr),
        .in_cr  (meas_corr),
        .sum_ip (acc_ip),
        .sum_qp (acc_qp),
        .sum_cr (acc_cr)
    );

    // Pick the current chain's sums and derive magnitude, sign and denominators.
    always_comb begin
        sel_ip     = acc_ip[idx_q*DW +: DW];
        sel_qp     = acc_qp[idx_q*DW +: DW];
        sel_cr     = acc_cr[idx_q*DW +: DW];
        corr_neg   = (sel_cr > HALF);
        corr_mag   = corr_neg ? DW'(~sel_cr + 1'b1) : sel_cr;
        den_ph     = DW'(({1'b0, sel_ip[DW-1:1]} + {1'b0, sel_qp[DW-1:1]}) >> PH_SH);
        den_gn     = sel_qp >> GN_SH;
        chain_live = mask_q[idx_q] && (den_ph != '0) && (den_gn != '0);
        last_chain = (idx_q == IDX_W'(NCH - 1));
        cnt_nx     = cnt_q + 1'b1;
    end

    // Divider operand steering: phase division first, gain division second.
    always_comb begin
        div_go = !start && ((state_q == ST_SETUP && chain_live) ||
                            (state_q == ST_DIV_PH && div_fin));
        div_a  = (state_q == ST_SETUP) ? corr_mag : sel_ip;
        div_b  = (state_q == ST_SETUP) ? den_ph   : den_gn;
    end

    iqc_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .quotient (div_q),
        .fin      (div_fin)
    );

    iqc_coef_calc #(.DW(DW), .CW(CW)) u_coef (
        .ph_quo   (phq_q),
        .gn_quo   (div_q),
        .corr_neg (neg_q),
        .coef_ph  (new_ph),
        .coef_gn  (new_gn)
    );

    // Sequencer: collection count, chain walk and result write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mask_q    <= '0;
            target_q  <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            neg_q     <= 1'b0;
            phq_q     <= '0;
            coef_ph_q <= '0;
            coef_gn_q <= '0;
            skip_q    <= '0;
            done_q    <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q  <= ST_COLLECT;
                mask_q   <= chain_en;
                target_q <= SCW'(1) << (SCW'(log_cnt) + SCW'(1));
                cnt_q    <= '0;
                idx_q    <= '0;
            end else begin
                unique case (state_q)
                    ST_COLLECT: begin
                        if (meas_vld) begin
                            cnt_q <= cnt_nx;
                            if (cnt_nx == target_q) begin
                                state_q <= ST_SETUP;
                                idx_q   <= '0;
                            end
                        end
                    end
                    ST_SETUP: begin
                        if (chain_live) begin
                            neg_q   <= corr_neg;
                            state_q <= ST_DIV_PH;
                        end else begin
                            skip_q[idx_q] <= 1'b1;
                            if (last_chain) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                en_q    <= 1'b1;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_DIV_PH: begin
                        if (div_fin) begin
                            phq_q   <= div_q;
                            state_q <= ST_DIV_GN;
                        end
                    end
                    ST_DIV_GN: begin
                        if (div_fin) begin
                            coef_ph_q[idx_q*CW +: CW] <= new_ph;
                            coef_gn_q[idx_q*CW +: CW] <= new_gn;
                            skip_q[idx_q]             <= 1'b0;
                            if (last_chain) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                                en_q    <= 1'b1;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                state_q <= ST_SETUP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign coef_phase = coef_ph_q;
    assign coef_gain  = coef_gn_q;
    assign skip       = skip_q;
    assign done       = done_q;
    assign corr_en    = en_q;

endmodule

// File: rtl/iqc_est_chk.sv
// Module: property checker for iqc_est, attached by bind.
// Assumes: observes top-level ports only.
module iqc_est_chk #(
    parameter int NCH = 3,
    parameter int CW  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [NCH*CW-1:0] coef_phase,
    input logic [NCH*CW-1:0] coef_gain,
    input logic [NCH-1:0]    skip,
    input logic              done,
    input logic              corr_en
);

    localparam logic [CW-1:0] MOST_NEG = {1'b1, {(CW-1){1'b0}}};

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        corr_en |=> corr_en); // R9
    AST_DONE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> corr_en); // R9
    AST_START_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R1

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_PH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            coef_phase[c*CW +: CW] != MOST_NEG); // R6
        AST_GN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            coef_gain[c*CW +: CW] != MOST_NEG); // R7
        AST_PH_FROZEN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(coef_phase[c*CW +: CW]) |-> !skip[c]); // R5
        AST_GN_FROZEN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(coef_gain[c*CW +: CW]) |-> !skip[c]); // R5
    end

endmodule

bind iqc_est iqc_est_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .coef_phase (coef_phase),
    .coef_gain  (coef_gain),
    .skip       (skip),
    .done       (done),
    .corr_en    (corr_en)
);

// File: tb/iqc_est_tb.sv
`timescale 1ns/1ps
// Bench: behavioural edge-numbered reference model, compared every cycle.
module iqc_est_tb;
    localparam int NCH = 3, DW = 32, CW = 7, LW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0, start = 1'b0, meas_vld = 1'b0;
    logic [LW-1:0]     log_cnt = '0;
    logic [NCH-1:0]    chain_en = '0;
    logic [NCH*DW-1:0] meas_ipwr, meas_qpwr, meas_corr;
    logic [NCH*CW-1:0] coef_phase, coef_gain;
    logic [NCH-1:0]    skip;
    logic              done, corr_en;
    logic [31:0]       d_ip[NCH], d_qp[NCH], d_cr[NCH];

    always_comb
        for (int c = 0; c < NCH; c++) begin
            meas_ipwr[c*DW +: DW] = d_ip[c];
            meas_qpwr[c*DW +: DW] = d_qp[c];
            meas_corr[c*DW +: DW] = d_cr[c];
        end

    iqc_est #(.NCH(NCH), .DW(DW), .CW(CW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .log_cnt(log_cnt),
        .chain_en(chain_en), .meas_vld(meas_vld), .meas_ipwr(meas_ipwr),
        .meas_qpwr(meas_qpwr), .meas_corr(meas_corr), .coef_phase(coef_phase),
        .coef_gain(coef_gain), .skip(skip), .done(done), .corr_en(corr_en)
    );

    int n_cmp = 0, n_bad = 0;
    bit chk_on = 0;
    string phase = "R10 reset";

    // ---------------- reference model ----------------
    int             edge_no = 0, m_mode = 0, m_cnt = 0, m_tgt = 0;
    logic [NCH-1:0] m_mask;
    logic [31:0]    s_ip[NCH], s_qp[NCH], s_cr[NCH];
    int             ev_edge[NCH];
    bit             ev_skip[NCH];
    logic [6:0]     ev_ph[NCH], ev_gn[NCH];
    logic           e_done = 0, e_en = 0;
    logic [NCH-1:0] e_skip = '0;
    logic [NCH*CW-1:0] e_ph = '0, e_gn = '0;

    function automatic void calc(input logic [31:0] ip, qp, cr,
                                 output bit sk, output logic [6:0] ph, gn);
        longint dph, dgn, mag, pq, gq;
        bit ng;
        dph = ((longint'(ip) >> 1) + (longint'(qp) >> 1)) >> 8;   // R5
        dgn = longint'(qp) >> 6;
        ng  = (cr > 32'h8000_0000);                               // R4
        mag = ng ? (64'h1_0000_0000 - longint'(cr)) : longint'(cr);
        sk = (dph == 0) || (dgn == 0);
        ph = '0; gn = '0;
        if (!sk) begin
            pq = mag / dph; if (pq > 63) pq = 63; if (!ng) pq = -pq;  // R6
            gq = longint'(ip) / dgn - 64;                              // R7
            if (gq > 63) gq = 63; if (gq < -63) gq = -63;
            ph = pq[6:0]; gn = gq[6:0];
        end
    endfunction

    always @(posedge clk) begin
        int p;
        edge_no++;
        if (!rst_n) begin
            m_mode = 0; e_done = 0; e_en = 0; e_skip = '0; e_ph = '0; e_gn = '0;
        end else begin
            e_done = 0;
            if (start) begin                        // R1
                m_mode = 1; m_cnt = 0; m_mask = chain_en;
                m_tgt = 1 << (int'(log_cnt) + 1);
                for (int c = 0; c < NCH; c++) begin s_ip[c] = 0; s_qp[c] = 0; s_cr[c] = 0; end
            end else if (m_mode == 1) begin
                if (meas_vld) begin                 // R2
                    for (int c = 0; c < NCH; c++)
                        if (m_mask[c]) begin
                            s_ip[c] += d_ip[c]; s_qp[c] += d_qp[c]; s_cr[c] += d_cr[c];
                        end
                    m_cnt++;
                    if (m_cnt == m_tgt) begin       // R3, R8 schedule
                        p = edge_no + 1;
                        for (int c = 0; c < NCH; c++) begin
                            bit sk; logic [6:0] a, b;
                            calc(s_ip[c], s_qp[c], s_cr[c], sk, a, b);
                            if (!m_mask[c]) sk = 1;
                            ev_skip[c] = sk; ev_ph[c] = a; ev_gn[c] = b;
                            if (sk) begin ev_edge[c] = p; p += 1; end
                            else begin ev_edge[c] = p + 66; p += 67; end
                        end
                        m_mode = 2;
                    end
                end
            end else if (m_mode == 2) begin
                for (int c = 0; c < NCH; c++)
                    if (ev_edge[c] == edge_no) begin
                        e_skip[c] = ev_skip[c];
                        if (!ev_skip[c]) begin
                            e_ph[c*CW +: CW] = ev_ph[c];
                            e_gn[c*CW +: CW] = ev_gn[c];
                        end
                        if (c == NCH - 1) begin e_done = 1; e_en = 1; m_mode = 0; end
                    end
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic cmp(input logic [63:0] act, exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s during [%s] actual=%0h expected=%0h", what, phase, act, exp);
        end
    endtask

    always @(negedge clk)
        if (chk_on) begin
            cmp(64'(done),       64'(e_done), "R9 done");
            cmp(64'(corr_en),    64'(e_en),   "R9 corr_en");
            cmp(64'(skip),       64'(e_skip), "R5 skip");
            cmp(64'(coef_phase), 64'(e_ph),   "R6 coef_phase");
            cmp(64'(coef_gain),  64'(e_gn),   "R7 coef_gain");
        end

    // ---------------- stimulus helpers ----------------
    task automatic setd(input int c, input logic [31:0] ip, qp, cr);
        d_ip[c] = ip; d_qp[c] = qp; d_cr[c] = cr;
    endtask

    task automatic kick(input logic [NCH-1:0] m, input int n, input bit with_vld);
        @(negedge clk);
        start = 1; chain_en = m; log_cnt = LW'(n); meas_vld = with_vld;
        @(negedge clk);
        start = 0; meas_vld = 0;
    endtask

    task automatic feed(input int gap);
        meas_vld = 1;
        @(negedge clk);
        meas_vld = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during [%s] actual=hung expected=finished", phase);
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) setd(c, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        // R10: all outputs zero after reset
        cmp(64'({coef_phase, coef_gain, skip, done, corr_en}), 64'd0, "R10 reset outputs");

        // Run A: all chains, N=0, positive, negative and zero-denominator cases (R2 R3 R4 R5 R6 R7 R8 R9)
        phase = "R4 R8 run A";
        kick(3'b111, 0, 0);
        setd(0, 32'h12000, 32'h10000, 32'h800);
        setd(1, 32'h8000, 32'h9000, 32'hFFFF_FC00);
        setd(2, 32'h5000, 32'h10, 32'h100);
        feed(0);
        feed(3);
        repeat (260) @(negedge clk);

        // Run B: chain1 masked (R2, R5 coefficients kept), correlation exactly 0x8000_0000, saturation (R6 R7)
        phase = "R2 R5 R6 R7 run B";
        kick(3'b101, 1, 0);
        setd(0, 32'h0400_0000, 32'h1000, 32'h2000_0000);
        setd(1, 32'h1000, 32'h1000, 32'h5);
        setd(2, 32'h100, 32'h0020_0000, 32'h3000);
        for (int i = 0; i < 4; i++) feed(i);
        repeat (260) @(negedge clk);

        // Run C: restart mid-collection; a strobe in the start cycle is dropped (R1)
        phase = "R1 run C restart";
        kick(3'b010, 0, 0);
        setd(1, 32'h30000, 32'h20000, 32'hFFFF_0000);
        feed(2);
        kick(3'b010, 0, 1);
        feed(1);
        feed(0);
        repeat (260) @(negedge clk);

        // Run D: start during computation abandons it (R1)
        phase = "R1 run D abort";
        kick(3'b001, 0, 0);
        setd(0, 32'h9000, 32'h9000, 32'h40);
        feed(0); feed(0);
        repeat (20) @(negedge clk);
        kick(3'b001, 0, 0);
        setd(0, 32'h7000, 32'h8000, 32'hFFFF_FF00);
        feed(0); feed(0);
        repeat (260) @(negedge clk);

        // Run E: N=2 (8 samples) with varied data and gaps (R3 R8)
        phase = "R3 R8 run E";
        kick(3'b111, 2, 0);
        for (int i = 0; i < 8; i++) begin
            setd(0, 32'h1000 + 32'(i) * 32'h300, 32'h1200, 32'(i) * 32'h40);
            setd(1, 32'h2000, 32'h1800 + 32'(i) * 32'h100, 32'hFFFF_FF80 - 32'(i));
            setd(2, 32'h800, 32'h900, 32'h10 * 32'(i));
            feed(i % 3);
        end
        repeat (260) @(negedge clk);
        // strobes while idle are ignored (R3)
        phase = "R3 idle strobes";
        feed(0); feed(0);
        repeat (10) @(negedge clk);

        summary();
        $finish;
    end

endmodule